// File: doc/BRIEF.md
# Bit-Band Alias Bus Translator

This unit sits between a simple memory-mapped master port and a 32-bit word-addressed slave that holds both RAM and peripheral registers. It watches every master address. An address inside one of two alias windows selects a single bit of a target word. One window maps onto the RAM region and the other onto the peripheral region, and each window and region has its own base. An address outside both windows goes to the slave unchanged.

An alias read fetches the target word and returns the chosen bit in bit 0. An alias write turns into a two-step sequence on the slave side. The unit first reads the target word, then writes it back with only the chosen bit replaced. A lock is held for the whole sequence, so no other request can reach the slave in between. Software can therefore flip one bit with a single store and needs no mask-and-write sequence of its own.

The sequencer has four states:
- `ST_IDLE` accepts requests.
- `ST_FWD_RD` returns forwarded read data.
- `ST_BIT_RD` returns an extracted alias bit.
- `ST_RMW_WR` writes back the modified word.

The transitions are:
- Idle to `ST_FWD_RD` on a read outside the windows.
- Idle to `ST_BIT_RD` on an alias read.
- Idle to `ST_RMW_WR` on an alias write.
- Idle stays in idle on a forwarded write.
- Every other state goes back to idle after one cycle.

Top module: `bitband_xlate`

## Requirements
- R1: An alias address equals the window base, plus 32 times the byte offset of the target word from its region base, plus 4 times the bit number (0..31). The slave access it produces uses the target word's byte address.
- R2: An alias read completes in 2 cycles. It returns the selected target bit in bit 0 of `m_rdata`, and bits 31..1 are zero.
- R3: An alias write sets the selected target bit to the written value. All other 31 bits of the target word keep their values.
- R4: An alias write uses only bit 0 of `m_wdata`. Bits 31..1 have no effect on the stored word.
- R5: An alias write is a slave read of the target word followed, in the next cycle, by a slave write of the same address. `s_lock` is high in both cycles.
- R6: During an alias write, `m_ready` stays low in the read cycle and goes high only in the write-back cycle, so the store takes 2 cycles.
- R7: Accesses outside both windows are forwarded with address and data unchanged. A write takes 1 cycle and a read takes 2 cycles. `s_lock` stays low.
- R8: The RAM window (default base 0x2200_0000) maps onto the RAM region (default 0x2000_0000). The peripheral window (default 0x4200_0000) maps onto the peripheral region (default 0x4000_0000). Each window reaches only its own region.
- R9: After reset, the unit is idle. `s_req`, `s_lock` and `m_ready` are low while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 1 | Master request, held until accepted |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | Access completes at the clock edge where it is high |
| m_rdata | output | 32 | Read data, valid while `m_ready` is high on a read |
| s_req | output | 1 | Slave access strobe |
| s_we | output | 1 | Slave write enable |
| s_addr | output | 32 | Slave byte address |
| s_wdata | output | 32 | Slave write data |
| s_rdata | input | 32 | Slave read data, one cycle after the read strobe |
| s_lock | output | 1 | Slave held exclusively for an alias read-modify-write |

## Verification
The bench first drives directed accesses:
- bit 0 and bit 31 of both regions, which separates correct bit-index arithmetic from an off-by-one in the shift;
- alias stores whose upper data bits are all ones, which exposes any use of data bits other than bit 0;
- the last word of a window, which exposes a wrong target offset.

It then mixes forwarded and alias reads and writes at random over both regions, and compares every read against a reference copy of the slave memory. A final direct sweep of all words catches any read-modify-write that disturbed neighbouring bits. Cycle counts, `s_lock` and the slave address are sampled on every access, which separates a correct two-step store from one that drops the lock or writes to the wrong word.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int BB_AW = 32;
    localparam int BB_DW = 32;
    localparam int BB_BW = $clog2(BB_DW);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FWD_RD = 2'd1,
        ST_BIT_RD = 2'd2,
        ST_RMW_WR = 2'd3
    } bb_state_e;

    typedef struct packed {
        logic             hit;
        logic [BB_AW-1:0] tgt;
        logic [BB_BW-1:0] bitn;
    } bb_map_t;
endpackage

// File: rtl/bb_win_decode.sv
module bb_win_decode
    import bb_pkg::*;
#(
    parameter logic [BB_AW-1:0] ALIAS_BASE   = 32'h2200_0000,
    parameter logic [BB_AW-1:0] TGT_BASE     = 32'h2000_0000,
    parameter int unsigned      REGION_BYTES = 32'h0010_0000
) (
    input  logic [BB_AW-1:0] addr,
    output bb_map_t          map
);
    localparam logic [BB_AW-1:0] SPAN = BB_AW'(REGION_BYTES * BB_DW);

    logic [BB_AW-1:0] offs;
    logic [BB_AW-1:0] word_off;

    always_comb begin
        offs     = addr - ALIAS_BASE;
        // each target byte spans DW alias bytes; drop the bit-select part
        word_off = (offs >> BB_BW) & ~BB_AW'(3);
        map.hit  = (addr >= ALIAS_BASE) && (offs < SPAN);
        map.tgt  = TGT_BASE + word_off;
        map.bitn = offs[BB_BW+1:2];
    end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_req,
    input  logic             m_we,
    input  logic [BB_AW-1:0] m_addr,
    input  logic [BB_DW-1:0] m_wdata,
    input  bb_map_t          map,
    input  logic [BB_DW-1:0] s_rdata,
    output logic             m_ready,
    output logic [BB_DW-1:0] m_rdata,
    output logic             s_req,
    output logic             s_we,
    output logic [BB_AW-1:0] s_addr,
    output logic [BB_DW-1:0] s_wdata,
    output logic             s_lock
);
    bb_state_e        state_q, state_d;
    logic [BB_AW-1:0] tgt_q;
    logic [BB_BW-1:0] bit_q;
    logic             val_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (m_req) begin
                    if (map.hit)   state_d = m_we ? ST_RMW_WR : ST_BIT_RD;
                    else if (!m_we) state_d = ST_FWD_RD;
                end
            end
            ST_FWD_RD: state_d = ST_IDLE;
            ST_BIT_RD: state_d = ST_IDLE;
            ST_RMW_WR: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            bit_q   <= '0;
            val_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && m_req && map.hit) begin
                tgt_q <= map.tgt;
                bit_q <= map.bitn;
                val_q <= m_wdata[0];
            end
        end
    end

    always_comb begin
        m_ready = 1'b0;
        m_rdata = '0;
        s_req   = 1'b0;
        s_we    = 1'b0;
        s_addr  = m_addr;
        s_wdata = m_wdata;
        s_lock  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (m_req) begin
                    s_req = 1'b1;
                    if (map.hit) begin
                        s_addr = map.tgt;
                        s_lock = m_we;
                    end else begin
                        s_we    = m_we;
                        m_ready = m_we;
                    end
                end
            end
            ST_FWD_RD: begin
                m_ready = 1'b1;
                m_rdata = s_rdata;
            end
            ST_BIT_RD: begin
                m_ready    = 1'b1;
                m_rdata[0] = s_rdata[bit_q];
            end
            ST_RMW_WR: begin
                m_ready        = 1'b1;
                s_req          = 1'b1;
                s_we           = 1'b1;
                s_lock         = 1'b1;
                s_addr         = tgt_q;
                s_wdata        = s_rdata;
                s_wdata[bit_q] = val_q;
            end
            default: ;
        endcase
    end

    AST_RMW_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RMW_WR) |-> $past(s_req && !s_we && s_lock)); // R5
    AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RMW_WR) |-> (s_addr == $past(s_addr))); // R5
    AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RMW_WR) |-> ($countones(s_wdata ^ s_rdata) <= 1)); // R3
    AST_ALIAS_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && m_req && map.hit && m_we) |-> !m_ready); // R6
    AST_BIT_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT_RD) |-> (m_rdata[BB_DW-1:1] == '0)); // R2
    AST_PASS_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FWD_RD) |-> !s_lock && $past(!s_lock)); // R7
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
    import bb_pkg::*;
#(
    parameter logic [31:0] RAM_BASE       = 32'h2000_0000,
    parameter logic [31:0] RAM_ALIAS_BASE = 32'h2200_0000,
    parameter logic [31:0] PER_BASE       = 32'h4000_0000,
    parameter logic [31:0] PER_ALIAS_BASE = 32'h4200_0000,
    parameter int unsigned REGION_BYTES   = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        m_req,
    input  logic        m_we,
    input  logic [31:0] m_addr,
    input  logic [31:0] m_wdata,
    output logic        m_ready,
    output logic [31:0] m_rdata,
    output logic        s_req,
    output logic        s_we,
    output logic [31:0] s_addr,
    output logic [31:0] s_wdata,
    input  logic [31:0] s_rdata,
    output logic        s_lock
);
    localparam int NWIN = 2;

    bb_map_t win_map [NWIN];
    bb_map_t sel_map;

    for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
        bb_win_decode #(
            .ALIAS_BASE  (gi == 0 ? RAM_ALIAS_BASE : PER_ALIAS_BASE),
            .TGT_BASE    (gi == 0 ? RAM_BASE : PER_BASE),
            .REGION_BYTES(REGION_BYTES)
        ) u_dec (
            .addr(m_addr),
            .map (win_map[gi])
        );
    end

    always_comb begin
        sel_map = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (win_map[i].hit) sel_map = win_map[i];
        end
    end

    bb_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .m_req  (m_req),
        .m_we   (m_we),
        .m_addr (m_addr),
        .m_wdata(m_wdata),
        .map    (sel_map),
        .s_rdata(s_rdata),
        .m_ready(m_ready),
        .m_rdata(m_rdata),
        .s_req  (s_req),
        .s_we   (s_we),
        .s_addr (s_addr),
        .s_wdata(s_wdata),
        .s_lock (s_lock)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_req && !$past(m_req)) |-> (!s_req && !m_ready && !s_lock)); // R9
    AST_WIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_map[1].hit, win_map[0].hit})); // R8
endmodule

// File: tb/bitband_xlate_tb.sv
module bitband_xlate_tb;
    localparam logic [31:0] RAM_B  = 32'h2000_0000;
    localparam logic [31:0] RAM_AL = 32'h2200_0000;
    localparam logic [31:0] PER_B  = 32'h4000_0000;
    localparam logic [31:0] PER_AL = 32'h4200_0000;
    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_we = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic        m_ready;
    logic [31:0] m_rdata;
    logic        s_req, s_we, s_lock;
    logic [31:0] s_addr, s_wdata;
    logic [31:0] s_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] ram_mem [NW];
    logic [31:0] per_mem [NW];
    logic [31:0] ram_ref [NW];
    logic [31:0] per_ref [NW];

    logic [31:0] exp_q [$];
    logic [31:0] act_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    bitband_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
        .m_rdata(m_rdata), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_lock(s_lock)
    );

    function automatic logic [31:0] init_word(int rg, int i);
        return 32'hA5C3_5A3C ^ (i * 32'h0111_1011) ^ (rg * 32'hFF00_00FF);
    endfunction

    // slave model: synchronous, read data one cycle after the strobe
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                ram_mem[i] <= init_word(0, i);
                per_mem[i] <= init_word(1, i);
            end
            s_rdata <= '0;
        end else if (s_req) begin
            if (s_we) begin
                if (s_addr[31:28] == 4'h2) ram_mem[s_addr[5:2]] <= s_wdata;
                else if (s_addr[31:28] == 4'h4) per_mem[s_addr[5:2]] <= s_wdata;
            end else begin
                if (s_addr[31:28] == 4'h2) s_rdata <= ram_mem[s_addr[5:2]];
                else if (s_addr[31:28] == 4'h4) s_rdata <= per_mem[s_addr[5:2]];
                else s_rdata <= '0;
            end
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected and actual read results and compares them
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            logic [31:0] e, a;
            string t;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            t = tag_q.pop_front();
            chk(a == e, t, a, e);
        end
    end

    function automatic logic [31:0] ref_rd(int rg, int w);
        return (rg == 0) ? ram_ref[w] : per_ref[w];
    endfunction

    task automatic ref_wr(int rg, int w, logic [31:0] v);
        if (rg == 0) ram_ref[w] = v; else per_ref[w] = v;
    endtask

    // driver: one master access; called right after a negedge
    task automatic access(bit we, logic [31:0] addr, logic [31:0] wd,
                          int exp_cyc, bit alias_acc, logic [31:0] tgt,
                          string tag);
        int cyc;
        cyc = 1;
        m_req = 1'b1; m_we = we; m_addr = addr; m_wdata = wd;
        #1;
        if (alias_acc) begin
            chk(s_req && s_addr == tgt, "R1 slave target address", s_addr, tgt);
            chk(s_lock == we, "R5 lock in read phase", {31'b0, s_lock}, {31'b0, we});
            if (we) chk(!m_ready, "R6 stall in read phase", {31'b0, m_ready}, 32'd0);
        end else begin
            chk(s_req && s_addr == addr && s_we == we && !s_lock,
                "R7 forwarded request", s_addr, addr);
            if (we) chk(s_wdata == wd, "R7 forwarded write data", s_wdata, wd);
        end
        forever begin
            if (m_ready) break;
            @(negedge clk); #1;
            cyc++;
            if (cyc > 8) break;
        end
        if (alias_acc && we) begin
            chk(s_req && s_we && s_lock && s_addr == tgt,
                "R5 locked write-back to same word", s_addr, tgt);
        end
        if (!we) begin
            act_q.push_back(m_rdata);
        end
        chk(cyc == exp_cyc, tag, cyc, exp_cyc);
        @(posedge clk);
        @(negedge clk);
        m_req = 1'b0;
    endtask

    task automatic alias_rd(int rg, int w, int b, string tag);
        logic [31:0] a, t;
        a = ((rg == 0) ? RAM_AL : PER_AL) + w * 128 + b * 4;
        t = ((rg == 0) ? RAM_B : PER_B) + w * 4;
        exp_q.push_back({31'b0, ref_rd(rg, w)[b]});
        tag_q.push_back(tag);
        access(1'b0, a, 32'h0, 2, 1'b1, t, "R2 alias read takes 2 cycles");
    endtask

    task automatic alias_wr(int rg, int w, int b, logic [31:0] d);
        logic [31:0] a, t, v;
        a = ((rg == 0) ? RAM_AL : PER_AL) + w * 128 + b * 4;
        t = ((rg == 0) ? RAM_B : PER_B) + w * 4;
        v = ref_rd(rg, w);
        v[b] = d[0];
        ref_wr(rg, w, v);
        access(1'b1, a, d, 2, 1'b1, t, "R6 alias write takes 2 cycles");
    endtask

    task automatic pass_rd(int rg, int w, string tag);
        logic [31:0] a;
        a = ((rg == 0) ? RAM_B : PER_B) + w * 4;
        exp_q.push_back(ref_rd(rg, w));
        tag_q.push_back(tag);
        access(1'b0, a, 32'h0, 2, 1'b0, a, "R7 forwarded read takes 2 cycles");
    endtask

    task automatic pass_wr(int rg, int w, logic [31:0] d);
        logic [31:0] a;
        a = ((rg == 0) ? RAM_B : PER_B) + w * 4;
        ref_wr(rg, w, d);
        access(1'b1, a, d, 1, 1'b0, a, "R7 forwarded write takes 1 cycle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            ram_ref[i] = init_word(0, i);
            per_ref[i] = init_word(1, i);
        end
        repeat (3) @(negedge clk);
        chk(!s_req && !s_lock && !m_ready, "R9 reset outputs quiet",
            {29'b0, s_req, s_lock, m_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!s_req && !s_lock && !m_ready, "R9 idle after reset",
            {29'b0, s_req, s_lock, m_ready}, 32'd0);

        // R2: bit extraction at both ends of the word, both regions
        alias_rd(0, 0, 0, "R2 ram bit 0");
        alias_rd(0, 3, 31, "R2 ram bit 31");
        alias_rd(1, 5, 31, "R8 per bit 31");
        alias_rd(1, 15, 0, "R1 last word per bit 0");

        // R3/R4: set and clear with junk upper bits
        alias_wr(0, 2, 31, 32'hFFFF_FFFE);
        pass_rd(0, 2, "R4 upper data bits ignored");
        alias_wr(0, 2, 0, 32'h0000_0001);
        alias_wr(0, 2, 17, 32'h8000_0000);
        pass_rd(0, 2, "R3 only selected bits change");

        // R8: peripheral window leaves RAM untouched
        alias_wr(1, 2, 5, ~per_ref[2][5] ? 32'h1 : 32'h0);
        pass_rd(1, 2, "R8 per word modified");
        pass_rd(0, 2, "R8 ram word not touched by per window");

        // R7: forwarded traffic
        pass_wr(0, 7, 32'hDEAD_BEEF);
        pass_rd(0, 7, "R7 forwarded read data");
        alias_rd(0, 7, 4, "R2 bit of forwarded write");

        // random mix
        for (int k = 0; k < 400; k++) begin
            int op, rg, w, b;
            op = $urandom_range(0, 3);
            rg = $urandom_range(0, 1);
            w  = $urandom_range(0, NW - 1);
            b  = $urandom_range(0, 31);
            case (op)
                0: pass_wr(rg, w, $urandom());
                1: pass_rd(rg, w, "R7 random forwarded read");
                2: alias_wr(rg, w, b, $urandom());
                default: alias_rd(rg, w, b, "R2 random alias read");
            endcase
        end

        // final sweep: neighbouring bits intact everywhere
        for (int rg = 0; rg < 2; rg++)
            for (int w = 0; w < NW; w++)
                pass_rd(rg, w, "R3 final memory sweep");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && act_q.size() == 0, "R2 scoreboard drained",
            exp_q.size(), 32'd0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule